// File: doc/BRIEF.md
# CRT Raster Timing Generator

This block produces the horizontal and vertical timing of a cathode-ray-tube style raster from a set of programmed values. It advances once per character clock, where one character is eight pixels. From that it derives horizontal sync, vertical sync, a blank flag and a display-enable flag. It also exposes its character and scan-line counters so that a fetch or serializer stage can follow the raster position.

All timing values use a biased encoding. The horizontal total is programmed as the character count minus five. Both display ends are programmed as the last visible position, that is the count minus one. The vertical total is programmed as the line count minus two. Sync ends are matched on a few low bits of the counter only. Sync polarity, line doubling and interlaced fields are chosen with separate control inputs.

Top module: `crt_timing_gen`

## Requirements
- R1: The character counter runs from 0 to h_total_m5+4 and then returns to 0, so a line lasts h_total_m5+5 cycles. A counter value at or above that limit, for example after the total was lowered, returns to 0 on the next cycle.
- R2: disp_en_o is 1 exactly when the character count is at most h_disp_end and the line is inside the vertical display region. blank_o is always the inverse of disp_en_o.
- R3: Horizontal sync becomes active on the cycle whose character count equals h_sync_start. It stays active until the first later count whose low 5 bits equal h_sync_end, and it is inactive from that count on. Counts of 32 or more therefore end it on their low 5 bits.
- R4: The line counter advances by one at the end of each character line. It runs from 0 to v_total_m2+1 and then returns to 0.
- R5: Without interlace, lines 0 through v_disp_end are in the vertical display region.
- R6: Vertical sync becomes active on the line equal to v_sync_start and ends at the first later line whose low 4 bits equal v_sync_end. Outside odd interlaced fields it changes together with the line counter.
- R7: With hsync_neg = 0 the hsync_o pin is high while sync is active; with hsync_neg = 1 it is low while active. vsync_neg acts the same way on vsync_o.
- R8: With dbl_scan = 1 every line is scanned twice: the line counter advances only after two character lines.
- R9: With interlace = 1, odd_field_o toggles at every frame wrap, and the vertical display region covers lines 0 through v_disp_end/2 (shifted right by one). With interlace = 0, odd_field_o stays 0.
- R10: In an odd interlaced field, vertical sync changes half a line late. The change appears on the cycle whose character count equals (h_total_m5+5)/2, rounded down.
- R11: A low rst_n sampled on a clock edge sets both counters to 0, clears odd_field_o and makes both syncs inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_total_m5 | input | 8 | Characters per line minus 5 |
| h_disp_end | input | 8 | Last displayed character |
| h_sync_start | input | 8 | Character count where hsync starts |
| h_sync_end | input | 5 | Low 5 bits of the count where hsync ends |
| v_total_m2 | input | 11 | Lines per frame minus 2 |
| v_disp_end | input | 11 | Last displayed line (full-frame value) |
| v_sync_start | input | 11 | Line where vsync starts |
| v_sync_end | input | 4 | Low 4 bits of the line where vsync ends |
| hsync_neg | input | 1 | 1 = hsync active low |
| vsync_neg | input | 1 | 1 = vsync active low |
| dbl_scan | input | 1 | 1 = each line scanned twice |
| interlace | input | 1 | 1 = interlaced fields |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| blank_o | output | 1 | Blanking flag |
| disp_en_o | output | 1 | Display enable |
| char_cnt_o | output | 9 | Character counter |
| line_cnt_o | output | 12 | Line counter |
| odd_field_o | output | 1 | Current field is odd |

## Verification
The bench builds the block with its default widths: 8-bit horizontal values, 11-bit vertical values, a 5-bit hsync end match and a 4-bit vsync end match. It programs very small rasters of 3 to 12 lines, which keeps whole frames short enough to count every sync, display and blank cycle over two frames. One raster uses a 45-character line with the sync starting at count 40. This reaches counts above 31, where the truncated hsync end match gives a result different from a full-width compare. Another raster shrinks the line total while the counter is past the new limit.

// File: rtl/crt_pkg.sv
// Shared types for the raster timing generator.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package crt_pkg;
    // Source of a vertical-sync evaluation step.
    typedef enum logic [1:0] {
        VEV_NONE = 2'd0,  // no update this cycle
        VEV_LINE = 2'd1,  // update at the line boundary
        VEV_HALF = 2'd2   // update at mid-line (odd interlaced field)
    } vev_e;
endpackage

// File: rtl/crt_hcount.sv
// Horizontal character counter and horizontal sync.
// Counts character clocks from 0 to total_m5+4. Flags the last character
// and the mid-line point. Sync starts on an exact match and ends on a
// match of the low SE_W bits. Assumes total_m5 is at most 2^H_W-1.
module crt_hcount #(
    parameter int H_W  = 8,
    parameter int SE_W = 5,
    localparam int CW  = H_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [H_W-1:0]  total_m5,
    input  logic [H_W-1:0]  disp_end,
    input  logic [H_W-1:0]  sync_start,
    input  logic [SE_W-1:0] sync_end,
    output logic [CW-1:0]   cnt,
    output logic            line_end,
    output logic            half_pt,
    output logic            h_disp,
    output logic            h_sync
);
    logic [CW-1:0] last_c;
    logic [CW-1:0] half_c;
    logic          hs_q;

    // Decode the end of the line and the mid-line point from the bias.
    always_comb begin
        last_c   = CW'(total_m5) + CW'(4);
        half_c   = (CW'(total_m5) + CW'(5)) >> 1;
        line_end = (cnt >= last_c);
        half_pt  = (cnt == half_c - CW'(1));
        h_disp   = (cnt <= CW'(disp_end));
        h_sync   = (cnt == CW'(sync_start)) ||
                   (hs_q && (cnt[SE_W-1:0] != sync_end));
    end

    // Advance the character counter and remember the sync state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            hs_q <= 1'b0;
        end else begin
            cnt  <= line_end ? '0 : cnt + CW'(1);
            hs_q <= h_sync;
        end
    end

    // R1: the counter restarts after the last character.
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (cnt == '0));

    // R3: a new sync pulse only begins at the programmed start count.
    assert_hs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sync && !hs_q) |-> (cnt == CW'(sync_start)));
endmodule

// File: rtl/crt_vcount.sv
// Vertical line counter, line doubling, field tracking and vertical sync.
// Advances on line_end from the horizontal counter. In an odd interlaced
// field, vsync is evaluated at the mid-line point instead of the line
// boundary. The display end is given at full-frame scale and halved here
// when interlaced.
module crt_vcount
    import crt_pkg::*;
#(
    parameter int V_W  = 11,
    parameter int SE_W = 4,
    localparam int LW  = V_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_end,
    input  logic            half_pt,
    input  logic [V_W-1:0]  total_m2,
    input  logic [V_W-1:0]  disp_end,
    input  logic [V_W-1:0]  sync_start,
    input  logic [SE_W-1:0] sync_end,
    input  logic            dbl,
    input  logic            ilace,
    output logic [LW-1:0]   line,
    output logic            odd_field,
    output logic            v_disp,
    output logic            v_sync
);
    logic          rep;
    logic          adv;
    logic          frame_end;
    logic [LW-1:0] last_l;
    logic [LW-1:0] line_nxt;
    logic [LW-1:0] vde_eff;
    logic [LW-1:0] ev_line;
    logic          vs_q;
    logic          vs_new;
    vev_e          ev;

    // Line advance, frame wrap and the display limit for this mode.
    always_comb begin
        last_l    = LW'(total_m2) + LW'(1);
        frame_end = (line >= last_l);
        adv       = line_end && (!dbl || rep);
        line_nxt  = frame_end ? '0 : line + LW'(1);
        vde_eff   = ilace ? LW'(disp_end >> 1) : LW'(disp_end);
        v_disp    = (line <= vde_eff);
    end

    // Choose when vsync is evaluated and for which line.
    always_comb begin
        if (ilace && odd_field)
            ev = (half_pt && (!dbl || !rep)) ? VEV_HALF : VEV_NONE;
        else
            ev = adv ? VEV_LINE : VEV_NONE;
        ev_line = (ev == VEV_LINE) ? line_nxt : line;
        vs_new  = (ev_line == LW'(sync_start)) ||
                  (vs_q && (ev_line[SE_W-1:0] != sync_end));
    end

    // Update the scan repeat, line, field and vsync state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep       <= 1'b0;
            line      <= '0;
            odd_field <= 1'b0;
            vs_q      <= 1'b0;
        end else begin
            if (line_end)
                rep <= dbl && !rep;
            if (adv) begin
                line <= line_nxt;
                if (frame_end)
                    odd_field <= ilace && !odd_field;
            end
            if (ev != VEV_NONE)
                vs_q <= vs_new;
        end
    end

    assign v_sync = vs_q;

    // R4: the line counter moves only at the end of a character line.
    assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(line));

    // R8: the first scan of a doubled line leaves the counter unchanged.
    assert_dbl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl && line_end && !rep) |=> $stable(line));

    // R9: the field flag changes only at a frame wrap.
    assert_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && frame_end) |=> $stable(odd_field));
endmodule

// File: rtl/crt_out_stage.sv
// Output stage: merges the horizontal and vertical display windows into
// display-enable and blank, and applies the selected sync polarity.
// Purely combinational; assumes its inputs come from registered logic.
module crt_out_stage (
    input  logic h_disp,
    input  logic v_disp,
    input  logic h_sync,
    input  logic v_sync,
    input  logic hsync_neg,
    input  logic vsync_neg,
    output logic hsync_o,
    output logic vsync_o,
    output logic blank_o,
    output logic disp_en_o
);
    // Combine the windows and invert the syncs when active-low is chosen.
    always_comb begin
        disp_en_o = h_disp && v_disp;
        blank_o   = !disp_en_o;
        hsync_o   = h_sync ^ hsync_neg;
        vsync_o   = v_sync ^ vsync_neg;
    end
endmodule

// File: rtl/crt_timing_gen.sv
// Top of the raster timing generator. Ties the horizontal counter, the
// vertical counter and the output stage together. One clock is one
// eight-pixel character. All timing values are biased register encodings.
module crt_timing_gen #(
    parameter int H_W   = 8,
    parameter int V_W   = 11,
    parameter int HSE_W = 5,
    parameter int VSE_W = 4,
    localparam int CW   = H_W + 1,
    localparam int LW   = V_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [H_W-1:0]   h_total_m5,
    input  logic [H_W-1:0]   h_disp_end,
    input  logic [H_W-1:0]   h_sync_start,
    input  logic [HSE_W-1:0] h_sync_end,
    input  logic [V_W-1:0]   v_total_m2,
    input  logic [V_W-1:0]   v_disp_end,
    input  logic [V_W-1:0]   v_sync_start,
    input  logic [VSE_W-1:0] v_sync_end,
    input  logic             hsync_neg,
    input  logic             vsync_neg,
    input  logic             dbl_scan,
    input  logic             interlace,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             blank_o,
    output logic             disp_en_o,
    output logic [CW-1:0]    char_cnt_o,
    output logic [LW-1:0]    line_cnt_o,
    output logic             odd_field_o
);
    logic line_end;
    logic half_pt;
    logic h_disp;
    logic h_sync;
    logic v_disp;
    logic v_sync;

    crt_hcount #(.H_W(H_W), .SE_W(HSE_W)) u_h (
        .clk        (clk),
        .rst_n      (rst_n),
        .total_m5   (h_total_m5),
        .disp_end   (h_disp_end),
        .sync_start (h_sync_start),
        .sync_end   (h_sync_end),
        .cnt        (char_cnt_o),
        .line_end   (line_end),
        .half_pt    (half_pt),
        .h_disp     (h_disp),
        .h_sync     (h_sync)
    );

    crt_vcount #(.V_W(V_W), .SE_W(VSE_W)) u_v (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end   (line_end),
        .half_pt    (half_pt),
        .total_m2   (v_total_m2),
        .disp_end   (v_disp_end),
        .sync_start (v_sync_start),
        .sync_end   (v_sync_end),
        .dbl        (dbl_scan),
        .ilace      (interlace),
        .line       (line_cnt_o),
        .odd_field  (odd_field_o),
        .v_disp     (v_disp),
        .v_sync     (v_sync)
    );

    crt_out_stage u_o (
        .h_disp    (h_disp),
        .v_disp    (v_disp),
        .h_sync    (h_sync),
        .v_sync    (v_sync),
        .hsync_neg (hsync_neg),
        .vsync_neg (vsync_neg),
        .hsync_o   (hsync_o),
        .vsync_o   (vsync_o),
        .blank_o   (blank_o),
        .disp_en_o (disp_en_o)
    );

    // R2: display is never enabled past the horizontal display end.
    assert_de_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en_o |-> (char_cnt_o <= CW'(h_disp_end)));
endmodule

// File: tb/tb_crt_timing_gen.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of small rasters measured over two
// frames, then directed tests for counter shrink and mid-run reset.
module tb_crt_timing_gen;
    typedef struct packed {
        int htm5; int hde; int hss; int hse;
        int vtm2; int vde; int vss; int vse;
        int hneg; int vneg; int dbl; int il;
        int frame; int de; int hs; int vs;
        int hrise; int vr1; int vr2;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{5, 5, 7, 9, 4, 2, 4, 5, 0, 0, 0, 0,  60, 36, 24, 20,  7, 40, 100},
        '{5, 5, 7, 9, 4, 2, 4, 5, 1, 1, 0, 0,  60, 36, 24, 20,  7, 40, 100},
        '{5, 5, 7, 9, 4, 2, 4, 5, 0, 0, 1, 0, 120, 72, 48, 40,  7, 80, 200},
        '{40, 31, 40, 9, 1, 0, 2, 0, 0, 0, 0, 0, 135, 64, 6, 90, 40, 90, 225},
        '{5, 5, 7, 9, 4, 5, 4, 5, 0, 0, 0, 1,  60, 36, 24, 20,  7, 40, 105}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  h_total_m5 = '0, h_disp_end = '0, h_sync_start = '0;
    logic [4:0]  h_sync_end = '0;
    logic [10:0] v_total_m2 = '0, v_disp_end = '0, v_sync_start = '0;
    logic [3:0]  v_sync_end = '0;
    logic        hsync_neg = 1'b0, vsync_neg = 1'b0, dbl_scan = 1'b0, interlace = 1'b0;
    logic        hsync_o, vsync_o, blank_o, disp_en_o, odd_field_o;
    logic [8:0]  char_cnt_o;
    logic [11:0] line_cnt_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    crt_timing_gen dut (
        .clk(clk), .rst_n(rst_n),
        .h_total_m5(h_total_m5), .h_disp_end(h_disp_end),
        .h_sync_start(h_sync_start), .h_sync_end(h_sync_end),
        .v_total_m2(v_total_m2), .v_disp_end(v_disp_end),
        .v_sync_start(v_sync_start), .v_sync_end(v_sync_end),
        .hsync_neg(hsync_neg), .vsync_neg(vsync_neg),
        .dbl_scan(dbl_scan), .interlace(interlace),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o),
        .disp_en_o(disp_en_o), .char_cnt_o(char_cnt_o),
        .line_cnt_o(line_cnt_o), .odd_field_o(odd_field_o)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        h_total_m5   = 8'(v.htm5);  h_disp_end = 8'(v.hde);
        h_sync_start = 8'(v.hss);   h_sync_end = 5'(v.hse);
        v_total_m2   = 11'(v.vtm2); v_disp_end = 11'(v.vde);
        v_sync_start = 11'(v.vss);  v_sync_end = 4'(v.vse);
        hsync_neg = v.hneg[0]; vsync_neg = v.vneg[0];
        dbl_scan  = v.dbl[0];  interlace = v.il[0];
    endtask

    // Leaves the bench at a negedge with the counters at cycle 0.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int de, hs, vs, hrise, vr1, vr2, bl_bad;
            bit hprev, vprev, ah, av;
            v = VECS[i];
            apply(v);
            do_reset();
            de = 0; hs = 0; vs = 0; hrise = -1; vr1 = -1; vr2 = -1; bl_bad = 0;
            hprev = 1'b0; vprev = 1'b0;
            for (int k = 0; k < 2 * v.frame; k++) begin
                ah = hsync_o ^ v.hneg[0];
                av = vsync_o ^ v.vneg[0];
                if (k == 0) begin
                    chk($sformatf("R11 v%0d reset char", i), int'(char_cnt_o), 0);
                    chk($sformatf("R11 v%0d reset line", i), int'(line_cnt_o), 0);
                    chk($sformatf("R7 v%0d idle hsync pin", i), int'(hsync_o), v.hneg);
                    chk($sformatf("R7 v%0d idle vsync pin", i), int'(vsync_o), v.vneg);
                end
                if (k == v.frame) begin
                    chk($sformatf("R1 v%0d char wrap", i), int'(char_cnt_o), 0);
                    chk($sformatf("R4 v%0d line wrap", i), int'(line_cnt_o), 0);
                    chk($sformatf("R9 v%0d field after one frame", i), int'(odd_field_o), v.il);
                end
                if (disp_en_o) de++;
                if (ah) hs++;
                if (av) vs++;
                if (ah && !hprev && hrise < 0) hrise = k;
                if (av && !vprev) begin
                    if (vr1 < 0) vr1 = k;
                    else if (vr2 < 0) vr2 = k;
                end
                if (blank_o == disp_en_o) bl_bad++;
                hprev = ah;
                vprev = av;
                @(negedge clk);
            end
            chk($sformatf("R2 R5 R8 R9 v%0d display cycles", i), de, v.de);
            chk($sformatf("R2 v%0d blank vs enable mismatches", i), bl_bad, 0);
            chk($sformatf("R3 R8 v%0d hsync cycles", i), hs, v.hs);
            chk($sformatf("R3 v%0d hsync first cycle", i), hrise, v.hrise);
            chk($sformatf("R6 v%0d vsync cycles", i), vs, v.vs);
            chk($sformatf("R6 R8 v%0d vsync first rise", i), vr1, v.vr1);
            chk($sformatf("R6 R10 v%0d vsync second rise", i), vr2, v.vr2);
            chk($sformatf("R9 v%0d field after two frames", i), int'(odd_field_o), 0);
        end

        // R1: lowering the total while the counter is past it wraps at once.
        apply(VECS[3]);
        do_reset();
        repeat (30) @(negedge clk);
        chk("R1 shrink precondition char", int'(char_cnt_o), 30);
        h_total_m5 = 8'd5;
        @(negedge clk);
        chk("R1 shrink char wraps", int'(char_cnt_o), 0);
        chk("R4 shrink line advances", int'(line_cnt_o), 1);

        // R11: reset in the middle of an odd interlaced field.
        apply(VECS[4]);
        do_reset();
        repeat (110) @(negedge clk);
        chk("R10 odd field vsync active mid-frame", int'(vsync_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 mid-run reset char", int'(char_cnt_o), 0);
        chk("R11 mid-run reset line", int'(line_cnt_o), 0);
        chk("R11 mid-run reset field", int'(odd_field_o), 0);
        chk("R11 mid-run reset vsync", int'(vsync_o), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule